// File: doc/BRIEF.md
# Streaming Modular Number-Theoretic Transform Stage

This block is one stage of a pipelined number-theoretic transform: an FFT-shaped computation carried out entirely in integer arithmetic modulo a prime `Q`. Each clock it may accept one pair of residues on two lanes, qualified by a valid strobe. It scales the second lane by a twiddle factor, forms the modular sum and difference, and passes the two result lanes through a commutator shuffle. The shuffle regroups the values so that the next stage finds its butterfly partners side by side.

The stage is parameterised by the transform size `N` (a power of two), its position `STAGE` in the cascade, the modulus `Q` and a primitive `N`-th root of unity `ROOT`. Twiddles are powers of `ROOT` held in a small table. The table is computed from the parameters when the design is elaborated, and a counter of accepted pairs indexes it. Chaining `log2(N)` instances with `STAGE` running upward builds a complete transform of up to 2^14 points. The whole transform serves as a modular Chinese remainder transform once an elementwise modular multiply has been applied in front of it. The input samples must already be residues in `[0, Q)`. The reset is asynchronous and active low, and it must be released synchronously to `clk`.

Top module: `ntt_stage`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` stays low until `D = 2^STAGE` pairs have been accepted.
- R2: For accepted pair index k with lanes x, y and twiddle w, the butterfly forms u = (x + w·y) mod Q and v = (x − w·y) mod Q. Both results lie in [0, Q), including when x or y equals Q−1 or 0.
- R3: The twiddle for pair index k (counted from 0 after reset, one per accepted pair) is w = ROOT^((k mod 2^STAGE)·N/2^(STAGE+1)) mod Q. The first pair of every block of 2^STAGE pairs therefore uses w = 1.
- R4: The output of step t ≥ D is defined as follows. Let j = t − D, g = j div 2D and m = j mod 2D. If m < D, `out_x`/`out_y` carry (u[2Dg+m], u[2Dg+m+D]). Otherwise they carry (v[2Dg+m−D], v[2Dg+m]).
- R5: The output of step t appears with `out_valid` high in the cycle after the second clock edge that follows the edge that accepted step t. `out_valid` is high for exactly one cycle per step t ≥ D and at no other time.
- R6: Cycles with `in_valid` low leave the pair counter, the twiddle sequence and the shuffle state untouched. The output sequence matches a run without gaps, shifted only in time.
- R7: When w = 1, the pair (u, v) equals the two-point DFT modulo Q of (x, y), with Q−1 as the square root of unity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair present this cycle |
| in_x | input | W | First input lane, residue in [0, Q) |
| in_y | input | W | Second input lane, residue in [0, Q) |
| out_valid | output | 1 | Output pair present this cycle |
| out_x | output | W | First output lane |
| out_y | output | W | Second output lane |

## Verification
Every output pair is due in the cycle after the second clock edge that follows the edge accepting the step that completes it. The driver stamps each expected pair with that cycle when it presents the step, and it queues nothing for the first D steps. Every cycle, the monitor requires `out_valid` to equal "the head of the queue is due now", and it compares the data whenever the two agree. This holds through runs of idle input cycles, so an early, late, missing or extra pair all fail. Expected lanes come from a modular model of the butterfly with its own power loop for the twiddles. Where the twiddle is 1, a direct two-point DFT supplies them instead.

// File: rtl/ntt_stage_pkg.sv
package ntt_stage_pkg;

  // base^e mod m, evaluated at elaboration to fill the twiddle table
  function automatic longint unsigned pow_mod(longint unsigned base,
                                              longint unsigned e,
                                              longint unsigned m);
    longint unsigned acc;
    longint unsigned b;
    acc = 1 % m;
    b   = base % m;
    for (longint unsigned j = 0; j < e; j++) begin
      acc = (acc * b) % m;
    end
    return acc;
  endfunction

endpackage

// File: rtl/ntt_twiddle_rom.sv
module ntt_twiddle_rom #(
  parameter int N     = 8,
  parameter int STAGE = 0,
  parameter int Q     = 17,
  parameter int ROOT  = 2,
  parameter int W     = 5,
  parameter int IDX_W = 1
) (
  input  logic [IDX_W-1:0] idx,
  output logic [W-1:0]     tw
);
  localparam int DEPTH = 1 << STAGE;
  localparam int STEP  = N >> (STAGE + 1);

  logic [W-1:0] table_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam longint unsigned VAL =
      ntt_stage_pkg::pow_mod(longint'(ROOT), longint'(i * STEP), longint'(Q));
    assign table_q[i] = W'(VAL);
  end

  if (STAGE == 0) begin : g_single
    logic unused_idx;
    assign unused_idx = ^idx;
    assign tw = table_q[0];
  end else begin : g_lookup
    assign tw = table_q[idx];
  end

endmodule

// File: rtl/ntt_butterfly.sv
module ntt_butterfly #(
  parameter int Q = 17,
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] tw,
  output logic         out_valid,
  output logic [W-1:0] out_u,
  output logic [W-1:0] out_v
);
  localparam logic [W:0]     QW  = (W + 1)'(Q);
  localparam logic [2*W-1:0] Q2W = (2 * W)'(Q);

  // stage 1: scale the second lane by the twiddle
  logic [2*W-1:0] mul_w;
  logic [W-1:0]   prod_d;
  logic           s1_valid_q;
  logic [W-1:0]   s1_x_q, s1_p_q;

  always_comb begin
    mul_w  = {{W{1'b0}}, tw} * {{W{1'b0}}, in_y};
    prod_d = W'(mul_w % Q2W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_x_q     <= '0;
      s1_p_q     <= '0;
    end else begin
      s1_valid_q <= in_valid;
      if (in_valid) begin
        s1_x_q <= in_x;
        s1_p_q <= prod_d;
      end
    end
  end

  // stage 2: modular sum and difference
  logic [W:0]   sum_w;
  logic [W-1:0] u_d, v_d;
  logic         s2_valid_q;
  logic [W-1:0] s2_u_q, s2_v_q;

  always_comb begin
    sum_w = {1'b0, s1_x_q} + {1'b0, s1_p_q};
    u_d   = (sum_w >= QW) ? W'(sum_w - QW) : W'(sum_w);
    if (s1_x_q >= s1_p_q) v_d = s1_x_q - s1_p_q;
    else                  v_d = W'({1'b0, s1_x_q} + QW - {1'b0, s1_p_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid_q <= 1'b0;
      s2_u_q     <= '0;
      s2_v_q     <= '0;
    end else begin
      s2_valid_q <= s1_valid_q;
      if (s1_valid_q) begin
        s2_u_q <= u_d;
        s2_v_q <= v_d;
      end
    end
  end

  assign out_valid = s2_valid_q;
  assign out_u     = s2_u_q;
  assign out_v     = s2_v_q;

  AST_BF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_u) < Q && int'(out_v) < Q)); // R2
  AST_BF_SUM_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((int'(out_u) + int'(out_v)) % Q) == ((2 * int'($past(in_x, 2))) % Q)); // R2
  AST_BF_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid); // R5

endmodule

// File: rtl/ntt_shuffle.sv
module ntt_shuffle #(
  parameter int STAGE = 0,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_u,
  input  logic [W-1:0] in_v,
  output logic         out_valid,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y
);
  localparam int D     = 1 << STAGE;
  localparam int CNT_W = STAGE + 1;

  logic [W-1:0]     vdly_q [D];
  logic [W-1:0]     vdly_d [D];
  logic [W-1:0]     tdly_q [D];
  logic [W-1:0]     tdly_d [D];
  logic [CNT_W-1:0] step_q, step_d;
  logic             primed_q, primed_d;
  logic             ovalid_q, ovalid_d;
  logic [W-1:0]     ox_q, oy_q;
  logic             blk;
  logic [W-1:0]     top_w, bot_w;

  always_comb begin
    blk = step_q[STAGE];
    if (!blk) begin
      top_w = in_u;
      bot_w = vdly_q[D-1];
    end else begin
      top_w = vdly_q[D-1];
      bot_w = in_u;
    end
    vdly_d[0] = in_v;
    tdly_d[0] = top_w;
    for (int i = 1; i < D; i++) begin
      vdly_d[i] = vdly_q[i-1];
      tdly_d[i] = tdly_q[i-1];
    end
    step_d   = step_q + CNT_W'(1);
    primed_d = primed_q | (step_q == CNT_W'(D - 1));
    ovalid_d = in_valid & primed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) begin
        vdly_q[i] <= '0;
        tdly_q[i] <= '0;
      end
      step_q   <= '0;
      primed_q <= 1'b0;
      ovalid_q <= 1'b0;
      ox_q     <= '0;
      oy_q     <= '0;
    end else begin
      ovalid_q <= ovalid_d;
      if (in_valid) begin
        for (int i = 0; i < D; i++) begin
          vdly_q[i] <= vdly_d[i];
          tdly_q[i] <= tdly_d[i];
        end
        step_q   <= step_d;
        primed_q <= primed_d;
      end
      if (ovalid_d) begin
        ox_q <= tdly_q[D-1];
        oy_q <= bot_w;
      end
    end
  end

  assign out_valid = ovalid_q;
  assign out_x     = ox_q;
  assign out_y     = oy_q;

  AST_SHF_ONLY_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid)); // R6
  AST_SHF_NOT_BEFORE_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed_q) |=> !out_valid); // R1

endmodule

// File: rtl/ntt_stage.sv
module ntt_stage #(
  parameter int N     = 8,
  parameter int STAGE = 0,
  parameter int Q     = 17,
  parameter int ROOT  = 2,
  parameter int W     = $clog2(Q)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  output logic         out_valid,
  output logic [W-1:0] out_x,
  output logic [W-1:0] out_y
);
  localparam int IDX_W = (STAGE == 0) ? 1 : STAGE;

  logic [IDX_W-1:0] pair_idx_q, pair_idx_d;
  logic [W-1:0]     tw;
  logic             bf_valid;
  logic [W-1:0]     bf_u, bf_v;

  always_comb begin
    pair_idx_d = in_valid ? pair_idx_q + IDX_W'(1) : pair_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pair_idx_q <= '0;
    else        pair_idx_q <= pair_idx_d;
  end

  ntt_twiddle_rom #(
    .N(N), .STAGE(STAGE), .Q(Q), .ROOT(ROOT), .W(W), .IDX_W(IDX_W)
  ) u_rom (
    .idx (pair_idx_q),
    .tw  (tw)
  );

  ntt_butterfly #(.Q(Q), .W(W)) u_bf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_y      (in_y),
    .tw        (tw),
    .out_valid (bf_valid),
    .out_u     (bf_u),
    .out_v     (bf_v)
  );

  ntt_shuffle #(.STAGE(STAGE), .W(W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (bf_valid),
    .in_u      (bf_u),
    .in_v      (bf_v),
    .out_valid (out_valid),
    .out_x     (out_x),
    .out_y     (out_y)
  );

  AST_TW_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pair_idx_q == '0) |-> (int'(tw) == 1)); // R3
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3)); // R5

endmodule

// File: tb/ntt_stage_tb.sv
`timescale 1ns/1ps
module ntt_stage_tb;
  localparam int N     = 8;
  localparam int STAGE = 1;
  localparam int Q     = 17;
  localparam int ROOT  = 2;
  localparam int W     = 5;
  localparam int D     = 1 << STAGE;
  localparam int MAXS  = 512;

  typedef struct {
    int    due;
    int    ex;
    int    ey;
    int    step;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [W-1:0] in_x, in_y;
  logic         out_valid;
  logic [W-1:0] out_x, out_y;

  int   cyc = 0;
  int   total = 0;
  int   fails = 0;
  int   nsteps = 0;
  bit   mon_on = 0;
  exp_t sb[$];
  int   u_h [MAXS];
  int   v_h [MAXS];
  bit   one_h [MAXS];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ntt_stage #(.N(N), .STAGE(STAGE), .Q(Q), .ROOT(ROOT), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
  );

  function automatic int powm(int b, int e);
    int r = 1;
    for (int i = 0; i < e; i++) r = (r * b) % Q;
    return r;
  endfunction

  task automatic check(bit ok, string req, int ax, int ay, int ex, int ey);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got (%0d,%0d) expected (%0d,%0d) at cycle %0d",
               req, ax, ay, ex, ey, cyc);
    end
  endtask

  // driver: presents one pair and queues the output it completes
  task automatic send(int x, int y);
    int t, w, base, g, m, i0;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1;
    in_x = W'(x);
    in_y = W'(y);
    t = nsteps;
    w = powm(ROOT, (t % (1 << STAGE)) * (N >> (STAGE + 1)));  // R3
    if (w == 1) begin
      // R7: two-point DFT with root Q-1
      u_h[t] = (x + y * powm(Q - 1, 0)) % Q;
      v_h[t] = (x + y * powm(Q - 1, 1)) % Q;
      one_h[t] = 1'b1;
    end else begin
      // R2: modular butterfly
      u_h[t] = (x + w * y) % Q;
      v_h[t] = (x + Q * Q - w * y) % Q;
      one_h[t] = 1'b0;
    end
    if (t >= D) begin
      base = t - D;
      g = base / (2 * D);
      m = base % (2 * D);
      if (m < D) begin
        i0 = g * 2 * D + m;
        e.ex = u_h[i0];
        e.ey = u_h[i0 + D];
      end else begin
        i0 = g * 2 * D + m - D;
        e.ex = v_h[i0];
        e.ey = v_h[i0 + D];
      end
      e.tag  = (one_h[i0] && one_h[i0 + D]) ? "R2 R4 R7" : "R2 R3 R4";
      e.due  = cyc + 3;  // R5
      e.step = t;
      sb.push_back(e);
    end
    nsteps++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_x = W'($urandom_range(0, Q - 1));
      in_y = W'($urandom_range(0, Q - 1));
    end
  endtask

  // monitor: out_valid must match exactly the due cycle of the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        bit due_now;
        exp_t e;
        due_now = (sb.size() > 0) && (sb[0].due == cyc);
        check(out_valid == due_now, "R1 R5 R6 valid", int'(out_valid), 0, int'(due_now), 0);
        if (out_valid && due_now) begin
          e = sb.pop_front();
          check(int'(out_x) == e.ex && int'(out_y) == e.ey, e.tag,
                int'(out_x), int'(out_y), e.ex, e.ey);
        end
      end
    end
  end

  initial begin
    #(100000 * 5);
    fails++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_x = '0;
    in_y = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset", int'(out_valid), 0, 0, 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    // wrap corners
    send(16, 16); send(16, 1); send(0, 16); send(1, 0);
    send(0, 0);   send(16, 0); send(8, 9);  send(3, 14);
    // gaps inside a group, R6
    idle(2); send(5, 12); idle(1); send(11, 6); idle(3); send(2, 15); send(9, 9);
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
      send($urandom_range(0, Q - 1), $urandom_range(0, Q - 1));
    end
    for (int i = 0; i < 16; i++) send(i % Q, (Q - 1 - i) % Q);
    idle(6);
    check(sb.size() == 0, "R5 drain", sb.size(), 0, 0, 0);
    mon_on = 1'b0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule